// File: doc/BRIEF.md
# Two-Master Shared Bus Segment

This block is one segment of an on-chip shared bus. Two masters and two slaves meet on it. A master raises its request line and waits for its grant. After that it drives select, read-not-write, address and write data, and holds them until it sees an acknowledge. The segment sends the granted master's lines to the slaves. It does this with AND terms gated by the grant, followed by OR gates, so no line ever has two drivers.

Address bit 15 picks the slave, provided all address bits above bit 15 are zero. Any address with an upper bit set is unmapped. An internal responder answers it, so the bus never stalls. Read data and acknowledge come back through a second AND-OR network, gated by the slave enables. They are then gated again by the grant, so only the owning master sees them.

A small registered arbiter decides which master owns the bus. It alternates between the masters when both want the bus. It never moves the grant in the middle of a transfer. A master may hold the bus across back-to-back transfers by raising its lock line. Signals are sampled on the rising clock edge, and reset is active low.

Top module: `shared_bus_seg`

## Requirements
- R1: When no master holds the bus and exactly one master requests, that master's grant goes high in the cycle after the clock edge that samples the request.
- R2: The two grant outputs are never high together.
- R3: The bus address, write data and read-not-write equal the granted master's inputs. With no grant they are all zero.
- R4: With select high from the owner and address bits above bit 15 all zero, address bit 15 = 0 raises `s0_en` and address bit 15 = 1 raises `s1_en`. At most one enable is high at a time.
- R5: Read data and acknowledge from the enabled slave reach only the granted master. The other master sees zero on both.
- R6: An address with any bit above bit 15 set enables neither slave. It is acknowledged by the segment in the cycle after the first edge that samples select, for exactly one cycle, with read data zero.
- R7: When the grant is re-decided and both masters request, the master that was not served last gets the bus.
- R8: While the owner's select is high and no acknowledge has arrived, the grant does not change.
- R9: If the owner holds lock high at the edge where its acknowledge is sampled, it keeps the grant, even while the other master requests.
- R10: An owner whose select and request are both low loses the grant at the next edge. The grant passes to the other master if that master is requesting.
- R11: During and right after reset both grants are low. If both masters request first, master 0 is served before master 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| m0_req | input | 1 | Master 0 bus request |
| m0_lock | input | 1 | Master 0 keeps the bus after its acknowledge |
| m0_sel | input | 1 | Master 0 transfer in progress |
| m0_rnw | input | 1 | Master 0 direction, 1 = read, 0 = write |
| m0_addr | input | AW | Master 0 address |
| m0_wdata | input | DW | Master 0 write data |
| m0_grant | output | 1 | Master 0 owns the bus |
| m0_ack | output | 1 | Transfer done, returned to master 0 |
| m0_rdata | output | DW | Read data returned to master 0 |
| m1_req | input | 1 | Master 1 bus request |
| m1_lock | input | 1 | Master 1 keeps the bus after its acknowledge |
| m1_sel | input | 1 | Master 1 transfer in progress |
| m1_rnw | input | 1 | Master 1 direction, 1 = read, 0 = write |
| m1_addr | input | AW | Master 1 address |
| m1_wdata | input | DW | Master 1 write data |
| m1_grant | output | 1 | Master 1 owns the bus |
| m1_ack | output | 1 | Transfer done, returned to master 1 |
| m1_rdata | output | DW | Read data returned to master 1 |
| bus_addr | output | AW | Shared address to the slaves |
| bus_wdata | output | DW | Shared write data to the slaves |
| bus_rnw | output | 1 | Shared direction to the slaves |
| s0_en | output | 1 | Slave 0 selected |
| s0_ack | input | 1 | Slave 0 acknowledge |
| s0_rdata | input | DW | Slave 0 read data |
| s1_en | output | 1 | Slave 1 selected |
| s1_ack | input | 1 | Slave 1 acknowledge |
| s1_rdata | input | DW | Slave 1 read data |

## Verification
The data path (bus lines, slave enables, returned data and acknowledge) is combinational. Each of these results is therefore due in the same cycle as the input that causes it. The bench checks them a quarter period after the falling edge on which the masters drive their inputs.

Grants and the unmapped-access acknowledge are registered. Each appears one cycle after the rising edge that samples its cause. The bench reference model advances its own owner, last-served and responder state only on rising edges, so its expectations fall due in exactly those cycles.

Every output is compared on every cycle. Further directed checks confirm the grant order, the grant held under lock, the release of the grant, and the returned read data.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int NUM_MASTERS = 2;
    localparam int NUM_TARGETS = 3; // two slaves plus the unmapped responder

    typedef struct packed {
        logic [NUM_MASTERS-1:0] grant;
        logic                   last;  // index of the master served most recently
    } arb_state_t;
endpackage

// File: rtl/sbus_andor.sv
module sbus_andor #(
    parameter int N = 2,
    parameter int W = 8
) (
    input  logic [N-1:0][W-1:0] din,
    input  logic [N-1:0]        en,
    output logic [W-1:0]        dout
);
    logic [N-1:0][W-1:0] term;

    for (genvar i = 0; i < N; i++) begin : g_and
        assign term[i] = din[i] & {W{en[i]}};
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | term[i];
        end
    end
endmodule

// File: rtl/sbus_arbiter.sv
module sbus_arbiter
    import sbus_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [NUM_MASTERS-1:0] lock,
    input  logic                   sel_bus,
    input  logic                   ack_bus,
    output logic [NUM_MASTERS-1:0] grant
);
    arb_state_t st_d, st_q;
    logic       owner;
    logic       held;
    logic [1:0] other_oh;

    always_comb begin
        st_d     = st_q;
        owner    = st_q.grant[1];
        held     = |st_q.grant;
        other_oh = owner ? 2'b01 : 2'b10;
        if (!held) begin
            if (&req) st_d.grant = st_q.last ? 2'b01 : 2'b10;
            else      st_d.grant = req;
        end else if (sel_bus && !ack_bus) begin
            st_d.grant = st_q.grant;
        end else if (sel_bus && lock[owner]) begin
            st_d.grant = st_q.grant;
        end else if (sel_bus) begin
            if (req[~owner])   st_d.grant = other_oh;
            else if (req[owner]) st_d.grant = st_q.grant;
            else               st_d.grant = '0;
        end else begin
            if (req[owner])     st_d.grant = st_q.grant;
            else if (req[~owner]) st_d.grant = other_oh;
            else                st_d.grant = '0;
        end
        if (|st_d.grant) st_d.last = st_d.grant[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.grant <= '0;
            st_q.last  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant && sel_bus && !ack_bus) |=> grant == $past(grant));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bus && ack_bus && |(grant & lock)) |=> grant == $past(grant));
endmodule

// File: rtl/sbus_decode.sv
module sbus_decode
    import sbus_pkg::*;
#(
    parameter int AW      = 20,
    parameter int SEL_BIT = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_bus,
    input  logic [AW-1:SEL_BIT]    addr_hi,
    output logic [NUM_TARGETS-1:0] tgt_en,
    output logic                   dflt_ack
);
    logic unmapped;
    logic dack_d, dack_q;

    always_comb begin
        unmapped  = |addr_hi[AW-1:SEL_BIT+1];
        tgt_en[0] = sel_bus && !unmapped && !addr_hi[SEL_BIT];
        tgt_en[1] = sel_bus && !unmapped &&  addr_hi[SEL_BIT];
        tgt_en[2] = sel_bus &&  unmapped;
        dack_d    = tgt_en[2] && !dack_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dack_q <= 1'b0;
        else        dack_q <= dack_d;
    end

    assign dflt_ack = dack_q;

    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_en));

    // R6
    dflt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_q |=> !dack_q);
endmodule

// File: rtl/shared_bus_seg.sv
module shared_bus_seg
    import sbus_pkg::*;
#(
    parameter int AW      = 20,
    parameter int DW      = 32,
    parameter int SEL_BIT = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m0_req,
    input  logic          m0_lock,
    input  logic          m0_sel,
    input  logic          m0_rnw,
    input  logic [AW-1:0] m0_addr,
    input  logic [DW-1:0] m0_wdata,
    output logic          m0_grant,
    output logic          m0_ack,
    output logic [DW-1:0] m0_rdata,
    input  logic          m1_req,
    input  logic          m1_lock,
    input  logic          m1_sel,
    input  logic          m1_rnw,
    input  logic [AW-1:0] m1_addr,
    input  logic [DW-1:0] m1_wdata,
    output logic          m1_grant,
    output logic          m1_ack,
    output logic [DW-1:0] m1_rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_rnw,
    output logic          s0_en,
    input  logic          s0_ack,
    input  logic [DW-1:0] s0_rdata,
    output logic          s1_en,
    input  logic          s1_ack,
    input  logic [DW-1:0] s1_rdata
);
    logic [NUM_MASTERS-1:0] grant;
    logic [1:0]             ctl_bus;
    logic                   sel_bus;
    logic                   ack_bus;
    logic [DW-1:0]          rdata_bus;
    logic [NUM_TARGETS-1:0] tgt_en;
    logic                   dflt_ack;

    sbus_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     ({m1_req, m0_req}),
        .lock    ({m1_lock, m0_lock}),
        .sel_bus (sel_bus),
        .ack_bus (ack_bus),
        .grant   (grant)
    );

    sbus_andor #(.N(NUM_MASTERS), .W(AW)) u_addr_mux (
        .din ({m1_addr, m0_addr}), .en (grant), .dout (bus_addr));

    sbus_andor #(.N(NUM_MASTERS), .W(DW)) u_wdata_mux (
        .din ({m1_wdata, m0_wdata}), .en (grant), .dout (bus_wdata));

    sbus_andor #(.N(NUM_MASTERS), .W(2)) u_ctl_mux (
        .din ({{m1_rnw, m1_sel}, {m0_rnw, m0_sel}}), .en (grant), .dout (ctl_bus));

    assign bus_rnw = ctl_bus[1];
    assign sel_bus = ctl_bus[0];

    sbus_decode #(.AW(AW), .SEL_BIT(SEL_BIT)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_bus  (sel_bus),
        .addr_hi  (bus_addr[AW-1:SEL_BIT]),
        .tgt_en   (tgt_en),
        .dflt_ack (dflt_ack)
    );

    assign s0_en = tgt_en[0];
    assign s1_en = tgt_en[1];

    sbus_andor #(.N(NUM_TARGETS), .W(DW)) u_rdata_mux (
        .din ({{DW{1'b0}}, s1_rdata, s0_rdata}), .en (tgt_en), .dout (rdata_bus));

    sbus_andor #(.N(NUM_TARGETS), .W(1)) u_ack_mux (
        .din ({dflt_ack, s1_ack, s0_ack}), .en (tgt_en), .dout (ack_bus));

    assign m0_grant = grant[0];
    assign m1_grant = grant[1];
    assign m0_ack   = ack_bus & grant[0];
    assign m1_ack   = ack_bus & grant[1];
    assign m0_rdata = rdata_bus & {DW{grant[0]}};
    assign m1_rdata = rdata_bus & {DW{grant[1]}};

    // R5
    single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m0_ack && m1_ack));

    // R3
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m0_grant || m1_grant) |-> (bus_addr == '0 && bus_wdata == '0 && !bus_rnw));
endmodule

// File: tb/shared_bus_seg_tb.sv
module shared_bus_seg_tb;
    localparam int CLK_P   = 10;
    localparam int AW      = 20;
    localparam int DW      = 32;
    localparam int WDOG    = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req = '0, lock = '0, sel = '0, rnw = '0;
    logic [AW-1:0] addr [2];
    logic [DW-1:0] wdat [2];
    logic [1:0] gnt, mack;
    logic [DW-1:0] mrd [2];
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic bus_rnw, s0_en, s1_en;
    logic s0_ack = 1'b0, s1_ack = 1'b0;
    logic [DW-1:0] s0_rdata, s1_rdata;
    logic m0_grant, m1_grant, m0_ack, m1_ack;
    logic [DW-1:0] m0_rdata, m1_rdata;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    shared_bus_seg u_dut (
        .clk(clk), .rst_n(rst_n),
        .m0_req(req[0]), .m0_lock(lock[0]), .m0_sel(sel[0]), .m0_rnw(rnw[0]),
        .m0_addr(addr[0]), .m0_wdata(wdat[0]),
        .m0_grant(m0_grant), .m0_ack(m0_ack), .m0_rdata(m0_rdata),
        .m1_req(req[1]), .m1_lock(lock[1]), .m1_sel(sel[1]), .m1_rnw(rnw[1]),
        .m1_addr(addr[1]), .m1_wdata(wdat[1]),
        .m1_grant(m1_grant), .m1_ack(m1_ack), .m1_rdata(m1_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rnw(bus_rnw),
        .s0_en(s0_en), .s0_ack(s0_ack), .s0_rdata(s0_rdata),
        .s1_en(s1_en), .s1_ack(s1_ack), .s1_rdata(s1_rdata)
    );

    assign gnt = {m1_grant, m0_grant};
    assign mack = {m1_ack, m0_ack};
    assign mrd[0] = m0_rdata;
    assign mrd[1] = m1_rdata;

    function automatic logic [DW-1:0] f0(input logic [AW-1:0] a);
        return DW'(a) ^ 32'hA5A5_0000;
    endfunction
    function automatic logic [DW-1:0] f1(input logic [AW-1:0] a);
        return DW'(a) + 32'h1000_0000;
    endfunction
    function automatic int region(input logic [AW-1:0] a);
        if (a[AW-1:16] != '0) return 2;
        return a[15] ? 1 : 0;
    endfunction

    // bench slaves: one-cycle acknowledge
    assign s0_rdata = f0(bus_addr);
    assign s1_rdata = f1(bus_addr);
    always @(posedge clk) begin
        s0_ack <= s0_en && !s0_ack;
        s1_ack <= s1_en && !s1_ack;
    end

    // reference model state
    int g = -1;
    bit last = 1;
    bit dack = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            g = -1; last = 1; dack = 0;
        end else begin
            bit sb, ab, dn;
            int r, ng;
            sb = (g >= 0) && sel[g];
            r  = sb ? region(addr[g]) : -1;
            ab = (r == 0) ? s0_ack : (r == 1) ? s1_ack : (r == 2) ? dack : 1'b0;
            dn = (r == 2) && !dack;
            ng = g;
            if (g < 0) begin
                if (req[0] && req[1]) ng = last ? 0 : 1;
                else if (req[0]) ng = 0;
                else if (req[1]) ng = 1;
            end else if (sb && !ab) begin
                ng = g;
            end else if (sb && lock[g]) begin
                ng = g;
            end else if (sb) begin
                if (req[1-g]) ng = 1 - g;
                else if (req[g]) ng = g;
                else ng = -1;
            end else begin
                if (req[g]) ng = g;
                else if (req[1-g]) ng = 1 - g;
                else ng = -1;
            end
            if (ng >= 0) last = ng[0];
            g = ng;
            dack = dn;
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    // per-cycle comparison a quarter period after the driving edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (!done) begin
            logic [AW-1:0] ea;
            logic [DW-1:0] ew, erd;
            logic er, eack, e0, e1;
            int r;
            ea = (g >= 0) ? addr[g] : '0;
            ew = (g >= 0) ? wdat[g] : '0;
            er = (g >= 0) ? rnw[g] : 1'b0;
            r  = ((g >= 0) && sel[g]) ? region(addr[g]) : -1;
            e0 = (r == 0);
            e1 = (r == 1);
            eack = (r == 0) ? s0_ack : (r == 1) ? s1_ack : (r == 2) ? dack : 1'b0;
            erd  = (r == 0) ? f0(addr[g]) : (r == 1) ? f1(addr[g]) : '0;
            chk(64'(gnt), 64'((g == 0) ? 2'b01 : (g == 1) ? 2'b10 : 2'b00),
                "R1 R7 R8 R9 R10 R11 grant");
            chk(64'(m0_grant && m1_grant), 64'd0, "R2 dual grant");
            chk(64'(bus_addr), 64'(ea), "R3 bus_addr");
            chk(64'(bus_wdata), 64'(ew), "R3 bus_wdata");
            chk(64'(bus_rnw), 64'(er), "R3 bus_rnw");
            chk(64'({s1_en, s0_en}), 64'({e1, e0}), "R4 R6 slave enables");
            chk(64'(mack), 64'((g == 0) ? {1'b0, eack} : (g == 1) ? {eack, 1'b0} : 2'b00),
                "R5 R6 ack");
            chk(64'(m0_rdata), 64'((g == 0) ? erd : '0), "R5 R6 m0_rdata");
            chk(64'(m1_rdata), 64'((g == 1) ? erd : '0), "R5 R6 m1_rdata");
        end
    end

    task automatic xfer(input int m, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic rd, input logic lk, input logic keep,
                        input logic [DW-1:0] exp_rd);
        req[m] = 1'b1;
        lock[m] = lk;
        do @(negedge clk); while (gnt[m] !== 1'b1);
        sel[m] = 1'b1; addr[m] = a; wdat[m] = d; rnw[m] = rd;
        do @(negedge clk); while (mack[m] !== 1'b1);
        if (rd) chk(64'(mrd[m]), 64'(exp_rd), "R5 R6 read data at ack");
        @(negedge clk);
        sel[m] = 1'b0;
        req[m] = keep;
    endtask

    initial begin
        addr[0] = '0; addr[1] = '0; wdat[0] = '0; wdat[1] = '0;
        repeat (3) @(negedge clk);
        chk(64'(gnt), 64'd0, "R11 grants in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(64'(gnt), 64'd0, "R11 grants after reset");

        // single master transfers, both slaves
        xfer(0, 20'h00010, 32'hDEAD_0001, 1'b0, 1'b0, 1'b0, '0);
        xfer(0, 20'h08020, 32'h0, 1'b1, 1'b0, 1'b0, f1(20'h08020));
        repeat (2) @(negedge clk);
        xfer(1, 20'h00044, 32'h0, 1'b1, 1'b0, 1'b0, f0(20'h00044));
        // unmapped read
        xfer(1, 20'h10004, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0);
        repeat (2) @(negedge clk);

        // R7: both request together; master 1 served last so master 0 wins
        fork
            xfer(0, 20'h00100, 32'h1111_0000, 1'b0, 1'b0, 1'b0, '0);
            xfer(1, 20'h08200, 32'h2222_0000, 1'b0, 1'b0, 1'b0, '0);
            begin
                @(negedge clk);
                chk(64'(gnt), 64'b01, "R7 round robin first winner");
            end
        join
        repeat (2) @(negedge clk);

        // R9: lock keeps the grant with master 0 while master 1 waits
        fork
            begin
                xfer(0, 20'h00300, 32'h3333_0000, 1'b0, 1'b1, 1'b1, '0);
                chk(64'(gnt), 64'b01, "R9 grant kept under lock");
                xfer(0, 20'h08304, 32'h0, 1'b1, 1'b0, 1'b0, f1(20'h08304));
            end
            begin
                @(negedge clk);
                @(negedge clk);
                xfer(1, 20'h00400, 32'h4444_0000, 1'b1, 1'b0, 1'b0, f0(20'h00400));
            end
        join
        repeat (2) @(negedge clk);

        // R10: owner drops request without a transfer
        req[0] = 1'b1;
        do @(negedge clk); while (gnt[0] !== 1'b1);
        req[0] = 1'b0;
        @(negedge clk);
        chk(64'(gnt), 64'd0, "R10 grant released");
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule